// File: doc/BRIEF.md
# Master-Clock to Frame Ratio Monitor

This block watches a converter interface and decides whether the master clock and the frame clock run locked together at the ratio that the current clocking mode requires. It runs in the master-clock domain. It brings the asynchronous frame clock in through a two-stage synchronizer and picks out a frame start from either the rising edge or the falling edge. It then counts master-clock cycles from one frame start to the next. When the DAC path runs from the PLL, a sample period must hold 256 master-clock cycles. When the DAC is clocked directly from the master clock, a period must hold 512 cycles.

The block also monitors a PLL lock input. A PLL that has not locked is a fault whenever either converter path uses the PLL, even if the DAC itself is clocked directly. A wrong period, a period that overruns, or a lock fault asserts the mute output for the DAC datapath. Mute stays asserted from reset. It is released only after a run of consecutive good periods with lock present. A sticky error bit records ratio mismatches until software clears it.

The control is a three-state machine:
- NO_REF means no frame start has been seen since reset.
- QUALIFY means the block is muted and counting good periods.
- RUN means the block is unmuted.

The transitions are:
- first_ref goes from NO_REF to QUALIFY on the first frame start.
- qualified goes from QUALIFY to RUN when the last required good period ends.
- fault goes from RUN to QUALIFY on a bad period, an overrun or a lock fault.
- requalify stays in QUALIFY and restarts the good-period count on any fault.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: After reset, mute is 1, ratio_err is 0 and period_count is 0.
- R2: A frame start is a rising edge of frame_clk when start_on_fall is 0, and a falling edge when start_on_fall is 1. The other edge of frame_clk has no effect.
- R3: period_count holds the number of master-clock cycles between the two most recent frame starts. It saturates at all ones (2^CNT_W-1).
- R4: The expected count is RATIO_PLL (default 256) when dac_direct is 0. It is RATIO_DIRECT (default 512) when dac_direct is 1.
- R5: A period whose count differs from the expected count asserts mute on the next cycle and restarts qualification. So does a running count that passes the expected count before the next frame start.
- R6: lock_fault equals (dac_direct is 0 or adc_pll is 1) and pll_locked is 0. It is computed combinationally. A lock fault forces mute on the next cycle and keeps it there, even when dac_direct is 1.
- R7: The first frame start after reset only sets the reference and measures nothing. Mute is released only when RELEASE_PERIODS (default 4) consecutive periods have ended with the expected count and no lock fault.
- R8: ratio_err is set by any mismatched or overrunning period and holds until err_clear is 1. A new error in the same cycle as err_clear takes priority over the clear.
- R9: Mute falls on the third master-clock rising edge that samples the frame_clk edge which completes qualification. The first such edge is the one that first sees the new frame_clk level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register is clocked by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Frame clock, asynchronous to mclk |
| start_on_fall | input | 1 | 1 selects the falling edge as the frame start |
| dac_direct | input | 1 | 1: DAC clocked directly from mclk (ratio RATIO_DIRECT); 0: DAC clocked by the PLL (ratio RATIO_PLL) |
| adc_pll | input | 1 | 1: ADC path is clocked by the PLL |
| pll_locked | input | 1 | PLL lock indication |
| err_clear | input | 1 | Clears the sticky ratio error |
| mute | output | 1 | Mute request to the DAC datapath |
| ratio_err | output | 1 | Sticky ratio mismatch flag |
| lock_fault | output | 1 | PLL needed but not locked |
| period_count | output | CNT_W | Length of the last measured period in mclk cycles |

## Verification
The embedded assertions check the following on every cycle:
- A bad or overrunning period always leads to mute on the next cycle.
- A lock fault always mutes.
- Mute only falls right after a good, lock-clean period ends.
- The sticky flag never drops without a clear.
- The period counter stays saturated once it is full.
- Frame-start pulses never last two cycles.

Only the bench scenarios can show that the measured counts are numerically right across ratios and modes. They also show that release comes after exactly the fourth good period and not before, that the edge selection actually changes which spacing is measured, and that the release latency is three edges.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // Supervisor states of the ratio monitor
    typedef enum logic [1:0] {
        MS_NO_REF  = 2'd0,   // no frame start seen since reset
        MS_QUALIFY = 2'd1,   // muted, counting good periods
        MS_RUN     = 2'd2    // unmuted
    } mon_state_t;

endpackage

// File: rtl/mcr_frame_sync.sv
module mcr_frame_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_async,
    input  logic start_on_fall,
    output logic frame_start
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;

    // Synchronizer chain, one flop per stage
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= frame_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // Delayed copy of the synchronized level, for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    always_comb begin
        if (start_on_fall) frame_start = prev_q & ~synced;
        else               frame_start = synced & ~prev_q;
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start)
        else $error("frame start lasted two cycles");

endmodule

// File: rtl/mcr_period_counter.sv
module mcr_period_counter #(
    parameter int RATIO_PLL    = 256,
    parameter int RATIO_DIRECT = 512,
    parameter int CNT_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             dac_direct,
    output logic             period_done,
    output logic             period_good,
    output logic             overrun,
    output logic [CNT_W-1:0] period_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EXP_PLL = CNT_W'(RATIO_PLL);
    localparam logic [CNT_W-1:0] EXP_DIR = CNT_W'(RATIO_DIRECT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic [CNT_W-1:0] expected;
    logic [CNT_W-1:0] measured;

    // The expected count depends on how the DAC is clocked
    always_comb begin
        expected = dac_direct ? EXP_DIR : EXP_PLL;
        measured = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    // Running counter and the capture of each completed period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (frame_start) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q) count_q <= measured;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        period_done  = frame_start & armed_q;
        period_good  = (measured == expected);
        overrun      = armed_q & ~frame_start & (cnt_q >= expected);
        period_count = count_q;
    end

    // R3
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX)
        else $error("period counter wrapped");

    // R7
    first_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !armed_q) |=> count_q == $past(count_q))
        else $error("reference edge produced a measurement");

endmodule

// File: rtl/mcr_mute_fsm.sv
module mcr_mute_fsm
    import mcr_pkg::*;
#(
    parameter int RELEASE_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic period_done,
    input  logic period_good,
    input  logic overrun,
    input  logic lock_fault,
    output logic mute
);

    localparam int GOOD_W = $clog2(RELEASE_PERIODS + 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RELEASE_PERIODS - 1);

    mon_state_t        state_q, state_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic              fault;
    logic              good_end;

    always_comb begin
        fault    = lock_fault | overrun | (period_done & ~period_good);
        good_end = period_done & period_good & ~lock_fault;
    end

    // Next-state and good-period counter
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        unique case (state_q)
            MS_NO_REF: begin
                if (frame_start) begin            // first_ref
                    state_d = MS_QUALIFY;
                    good_d  = '0;
                end
            end
            MS_QUALIFY: begin
                if (fault) begin                  // requalify
                    good_d = '0;
                end else if (good_end) begin
                    if (good_q == GOOD_LAST) begin // qualified
                        state_d = MS_RUN;
                        good_d  = '0;
                    end else begin
                        good_d = good_q + 1'b1;
                    end
                end
            end
            MS_RUN: begin
                if (fault) begin                  // fault
                    state_d = MS_QUALIFY;
                    good_d  = '0;
                end
            end
            default: begin
                state_d = MS_NO_REF;
                good_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_NO_REF;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    // Outputs
    always_comb begin
        mute = (state_q != MS_RUN);
    end

    // R5
    bad_period_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun || (period_done && !period_good)) |=> mute)
        else $error("bad period did not mute");

    // R7
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> $past(period_done && period_good && !lock_fault))
        else $error("mute released without a good period");

    // R7
    good_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_q <= GOOD_LAST)
        else $error("good-period count out of range");

endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor #(
    parameter int RATIO_PLL       = 256,
    parameter int RATIO_DIRECT    = 512,
    parameter int RELEASE_PERIODS = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int CNT_W           = $clog2(RATIO_DIRECT + 1) + 1
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic             start_on_fall,
    input  logic             dac_direct,
    input  logic             adc_pll,
    input  logic             pll_locked,
    input  logic             err_clear,
    output logic             mute,
    output logic             ratio_err,
    output logic             lock_fault,
    output logic [CNT_W-1:0] period_count
);

    logic frame_start;
    logic period_done;
    logic period_good;
    logic overrun;
    logic bad_evt;
    logic err_q;

    mcr_frame_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk           (mclk),
        .rst_n         (rst_n),
        .frame_async   (frame_clk),
        .start_on_fall (start_on_fall),
        .frame_start   (frame_start)
    );

    mcr_period_counter #(
        .RATIO_PLL    (RATIO_PLL),
        .RATIO_DIRECT (RATIO_DIRECT),
        .CNT_W        (CNT_W)
    ) u_count (
        .clk          (mclk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .dac_direct   (dac_direct),
        .period_done  (period_done),
        .period_good  (period_good),
        .overrun      (overrun),
        .period_count (period_count)
    );

    // The PLL is needed if it clocks either converter path
    always_comb begin
        lock_fault = (~dac_direct | adc_pll) & ~pll_locked;
        bad_evt    = overrun | (period_done & ~period_good);
    end

    mcr_mute_fsm #(
        .RELEASE_PERIODS (RELEASE_PERIODS)
    ) u_fsm (
        .clk         (mclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .period_done (period_done),
        .period_good (period_good),
        .overrun     (overrun),
        .lock_fault  (lock_fault),
        .mute        (mute)
    );

    // Sticky ratio error: a new error takes priority over the clear
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (bad_evt)   err_q <= 1'b1;
        else if (err_clear) err_q <= 1'b0;
    end

    assign ratio_err = err_q;

    // R8
    sticky_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (ratio_err && !err_clear) |=> ratio_err)
        else $error("ratio error dropped without clear");

    // R8
    err_set_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        bad_evt |=> ratio_err)
        else $error("ratio error not recorded");

    // R6
    lock_mute_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        lock_fault |=> mute)
        else $error("lock fault did not mute");

endmodule

// File: tb/test_mclk_ratio_monitor.sv
module test_mclk_ratio_monitor;

    localparam int RP    = 16;
    localparam int RD    = 32;
    localparam int REL   = 4;
    localparam int CW    = $clog2(RD + 1) + 1;
    localparam int CMAX  = (1 << CW) - 1;

    logic          mclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_clk = 1'b0;
    logic          start_on_fall = 1'b0;
    logic          dac_direct = 1'b0;
    logic          adc_pll = 1'b0;
    logic          pll_locked = 1'b1;
    logic          err_clear = 1'b0;
    logic          mute;
    logic          ratio_err;
    logic          lock_fault;
    logic [CW-1:0] period_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 mclk = ~mclk;

    mclk_ratio_monitor #(
        .RATIO_PLL       (RP),
        .RATIO_DIRECT    (RD),
        .RELEASE_PERIODS (REL),
        .SYNC_STAGES     (2)
    ) i_mclk_ratio_monitor (
        .mclk          (mclk),
        .rst_n         (rst_n),
        .frame_clk     (frame_clk),
        .start_on_fall (start_on_fall),
        .dac_direct    (dac_direct),
        .adc_pll       (adc_pll),
        .pll_locked    (pll_locked),
        .err_clear     (err_clear),
        .mute          (mute),
        .ratio_err     (ratio_err),
        .lock_fault    (lock_fault),
        .period_count  (period_count)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge mclk);
    endtask

    task automatic do_reset();
        @(negedge mclk);
        rst_n     = 1'b0;
        frame_clk = 1'b0;
        err_clear = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
    endtask

    // k periods of n cycles; high phase alternates hi0 / hi1
    task automatic send_periods(input int n, input int k, input int hi0, input int hi1);
        for (int p = 0; p < k; p++) begin
            for (int i = 0; i < n; i++) begin
                @(negedge mclk);
                frame_clk = (i < ((p % 2 == 1) ? hi1 : hi0));
            end
        end
    endtask

    task automatic close_edge();
        @(negedge mclk);
        frame_clk = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge mclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(mute, 1, "R1 mute");
        chk(ratio_err, 0, "R1 ratio_err");
        chk(period_count, 0, "R1 period_count");

        // R4 R5 R7 R9 sweep of period length in both clock modes
        for (int dd = 0; dd < 2; dd++) begin
            for (int delta = -2; delta <= 2; delta++) begin
                int expv;
                dac_direct = dd[0];
                adc_pll    = 1'b0;
                pll_locked = 1'b1;
                do_reset();
                expv = (dd == 1) ? RD : RP;
                send_periods(expv + delta, REL, 2, 2);
                close_edge();
                tick(2);
                chk(mute, 1, "R9 mute before release edge");
                tick(1);
                chk(mute, (delta != 0) ? 1 : 0, "R4 R5 R7 mute after periods");
                chk(ratio_err, (delta != 0) ? 1 : 0, "R5 ratio_err");
                chk(period_count, expv + delta, "R3 R4 period_count");
            end
        end

        // R7 three good periods do not release
        dac_direct = 1'b0;
        do_reset();
        send_periods(RP, REL - 1, 2, 2);
        close_edge();
        tick(6);
        chk(mute, 1, "R7 early release");

        // R5 bad period after release
        do_reset();
        send_periods(RP, REL, 2, 2);
        send_periods(RP - 1, 1, 2, 2);
        close_edge();
        tick(3);
        chk(mute, 1, "R5 mute after short period");
        chk(ratio_err, 1, "R5 error after short period");
        chk(period_count, RP - 1, "R3 short period count");

        // R3 saturation
        do_reset();
        send_periods(CMAX + 13, 1, 2, 2);
        close_edge();
        tick(3);
        chk(period_count, CMAX, "R3 saturation");
        chk(ratio_err, 1, "R5 overrun error");
        // R8 clear
        err_clear = 1'b1;
        tick(1);
        err_clear = 1'b0;
        chk(ratio_err, 0, "R8 clear");
        // R8 error wins over clear
        err_clear = 1'b1;
        tick(RP + 4);
        chk(ratio_err, 1, "R8 set wins over clear");
        err_clear = 1'b0;

        // R2 edge selection
        start_on_fall = 1'b0;
        do_reset();
        send_periods(RP, 6, 2, 6);
        close_edge();
        tick(3);
        chk(mute, 0, "R2 rising start ignores fall spacing");
        chk(ratio_err, 0, "R2 rising start no error");
        start_on_fall = 1'b1;
        do_reset();
        send_periods(RP, 6, 2, 6);
        tick(3);
        chk(mute, 1, "R2 falling start sees uneven spacing");
        chk(ratio_err, 1, "R2 falling start error");
        do_reset();
        send_periods(RP, 6, 4, 4);
        tick(3);
        chk(mute, 0, "R2 falling start even spacing");
        chk(period_count, RP, "R2 falling start count");
        start_on_fall = 1'b0;

        // R6 lock handling
        dac_direct = 1'b1;
        adc_pll    = 1'b0;
        pll_locked = 1'b0;
        do_reset();
        chk(lock_fault, 0, "R6 direct DAC without PLL use");
        send_periods(RD, REL, 2, 2);
        close_edge();
        tick(3);
        chk(mute, 0, "R6 direct release with PLL unlocked and unused");
        adc_pll = 1'b1;
        #1;
        chk(lock_fault, 1, "R6 ADC on PLL unlocked");
        tick(1);
        chk(mute, 1, "R6 lock fault mutes direct DAC");
        do_reset();
        send_periods(RD, REL + 2, 2, 2);
        close_edge();
        tick(3);
        chk(mute, 1, "R6 no release while unlocked");
        chk(ratio_err, 0, "R6 lock fault is not a ratio error");
        dac_direct = 1'b0;
        adc_pll    = 1'b0;
        #1;
        chk(lock_fault, 1, "R6 PLL-clocked DAC unlocked");
        pll_locked = 1'b1;
        #1;
        chk(lock_fault, 0, "R6 locked");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule